// File: doc/BRIEF.md
# Repeated String Scan/Store Engine

This block walks a buffer in memory one element at a time, under the control of a small sequencer. A start command brings in the configuration:
- an index (the address of the current element),
- a repeat counter,
- an accumulator value,
- an element width (8, 16 or 32 bits),
- a walking direction,
- an address mode (16-bit or 32-bit index),
- a mode: store or scan.

In store mode the engine writes the low element of the accumulator to the address held in the index, and the status flags are left alone. In scan mode it reads the element at the index and subtracts it from the accumulator. The difference is discarded, and the carry, parity, auxiliary-borrow, zero, sign and overflow flags are updated from it. After every element the index moves up or down by the element width in bytes.

With repeat off, exactly one element is handled. With repeat on, the counter is decremented once per element and the walk ends when it reaches zero. A scan can also end early: in while-equal mode it stops on the first mismatch, and in while-not-equal mode it stops on the first match. A repeat that starts with a count of zero touches no memory.

The memory side is a single request/ready port with one element per handshake. When the walk ends, the final index, the final counter and the flags are presented, and a one-cycle done pulse is raised.

Top module: `str_walk_engine`

## Requirements
- R1: After reset `done_o`, `mem_req_o` and `busy_o` are 0, and `idx_o`, `cnt_o` and `flags_o` are all zero.
- R2: Store mode drives `mem_we_o`=1 and `mem_wdata_o` equal to the accumulator masked to the element width (upper bits zero). A store never changes `flags_o`.
- R3: Scan mode drives `mem_we_o`=0 and computes (accumulator − memory element) over the element width only. The flags are packed in `flags_o` as follows:
  - bit 0: unsigned borrow;
  - bit 1: set when the low byte of the difference has an even number of ones;
  - bit 2: borrow out of bit 3;
  - bit 3: the difference is zero;
  - bit 4: most significant bit of the difference;
  - bit 5: signed overflow, i.e. the operands differ in sign and the difference's sign differs from the accumulator's.
- R4: After each element the index grows by 1, 2 or 4 (`size_i` 0, 1, 2 respectively) when `dir_i`=0, and shrinks by the same step when `dir_i`=1.
- R5: With `wide_i`=0 only the low 16 bits of the index step, wrapping within 16 bits; the upper index bits are kept, and `mem_addr_o` carries the low 16 bits with the upper bits zero. With `wide_i`=1 all index bits are used.
- R6: With `rep_i`=1 and a nonzero count N (and no early stop), exactly N elements are handled and `cnt_o` ends at 0.
- R7: With `rep_i`=1 and `cnt_i`=0, the done pulse rises on the first edge after start, no request is made, and `idx_o`/`cnt_o` equal the start values.
- R8: `rep_cond_i` encodes the early-stop mode: 1 is while-equal and 2 is while-not-equal, while 0 and 3 disable early stop. In scan mode, while-equal ends after the first element whose zero flag is 0, and while-not-equal ends after the first element whose zero flag is 1. The counter is decremented for that element too.
- R9: Once raised, `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stay stable until `mem_rdy_i` is sampled high. Exactly one element completes per handshake.
- R10: With `rep_i`=0 exactly one element is handled and `cnt_o` keeps the loaded count.
- R11: `done_o` is a single-cycle pulse in the cycle after the last handshake, with no request pending. A start asserted while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command (taken only when idle) |
| scan_i | input | 1 | 1 = scan mode, 0 = store mode |
| rep_i | input | 1 | Repeat enable |
| rep_cond_i | input | 2 | Early-stop mode for repeated scans |
| size_i | input | 2 | Element width: 0 byte, 1 16-bit, 2 32-bit |
| dir_i | input | 1 | 0 = index up, 1 = index down |
| wide_i | input | 1 | 1 = 32-bit index, 0 = 16-bit index |
| idx_i | input | AW | Start index |
| cnt_i | input | CW | Start count |
| acc_i | input | DW | Accumulator value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | DW | Write data, element in low bits |
| mem_size_o | output | 2 | Element width code |
| mem_rdata_i | input | DW | Read data, element in low bits |
| mem_rdy_i | input | 1 | Memory ready, completes the handshake |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| idx_o | output | AW | Current/final index |
| cnt_o | output | CW | Current/final count |
| flags_o | output | 6 | Status flags, layout per R3 |

## Verification
The bound checker watches, on every cycle:
- that the request and its payload are held while ready is low;
- that the address advances by the element step after each completed element;
- that the counter drops by one per repeated element and is held otherwise;
- that stores leave the flags untouched;
- that a zero-count repeat completes at once;
- that done is a lone pulse with no request pending.

Only the bench scenarios can show the following:
- the arithmetic value of each flag for chosen operand pairs and widths;
- where a while-equal or while-not-equal walk stops in a patterned buffer;
- 16-bit index wrap-around;
- that a start issued mid-walk leaves the final index and count unchanged.

// File: rtl/str_walk_pkg.sv
`timescale 1ns/1ps
package str_walk_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } elem_size_e;

  typedef enum logic [1:0] {
    RC_NONE     = 2'd0,
    RC_WHILE_EQ = 2'd1,
    RC_WHILE_NE = 2'd2,
    RC_RSVD     = 2'd3
  } rep_cond_e;

  // bit 0 = cry ... bit 5 = ovf
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);

  function automatic logic [2:0] elem_bytes(elem_size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/str_idx_step.sv
`timescale 1ns/1ps
module str_idx_step
  import str_walk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] idx_i,
  input  elem_size_e    size_i,
  input  logic          dir_i,
  input  logic          wide_i,
  output logic [AW-1:0] idx_nxt_o,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] step;
  logic [AW-1:0] full;

  always_comb begin
    step = AW'(elem_bytes(size_i));
    full = dir_i ? (idx_i - step) : (idx_i + step);
  end

  generate
    if (AW > 16) begin : g_split
      assign idx_nxt_o = wide_i ? full  : {idx_i[AW-1:16], full[15:0]};
      assign addr_o    = wide_i ? idx_i : {{(AW-16){1'b0}}, idx_i[15:0]};
    end else begin : g_narrow
      assign idx_nxt_o = full;
      assign addr_o    = idx_i;
    end
  endgenerate

endmodule

// File: rtl/str_sub_flags.sv
`timescale 1ns/1ps
module str_sub_flags
  import str_walk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] mem_i,
  input  elem_size_e    size_i,
  output flags_t        flags_o
);

  localparam int SH_B = DW - 8;
  localparam int SH_W = DW - 16;
  localparam int SH_D = DW - 32;

  logic [DW-1:0] a_al, m_al, r_al;
  logic [7:0]    lo_diff;

  // left-align the element so one subtractor serves all widths
  always_comb begin
    case (size_i)
      SZ_BYTE: begin a_al = acc_i << SH_B; m_al = mem_i << SH_B; end
      SZ_WORD: begin a_al = acc_i << SH_W; m_al = mem_i << SH_W; end
      default: begin a_al = acc_i << SH_D; m_al = mem_i << SH_D; end
    endcase
    r_al    = a_al - m_al;
    lo_diff = acc_i[7:0] - mem_i[7:0];

    flags_o.cry = a_al < m_al;
    flags_o.zro = (r_al == '0);
    flags_o.sgn = r_al[DW-1];
    flags_o.ovf = (a_al[DW-1] ^ m_al[DW-1]) & (r_al[DW-1] ^ a_al[DW-1]);
    flags_o.aux = acc_i[3:0] < mem_i[3:0];
    flags_o.par = ~^lo_diff;
  end

endmodule

// File: rtl/str_seq_ctrl.sv
`timescale 1ns/1ps
module str_seq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic zero_skip_i,
  input  logic hs_i,
  input  logic last_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o
);

  typedef enum logic {ST_IDLE, ST_XFER} st_e;

  st_e  st_q;
  logic done_q;

  assign accept_o = (st_q == ST_IDLE) && start_i;
  assign busy_o   = (st_q == ST_XFER);
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (zero_skip_i) done_q <= 1'b1;
            else             st_q   <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (hs_i && last_i) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/str_walk_engine.sv
`timescale 1ns/1ps
module str_walk_engine
  import str_walk_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          scan_i,
  input  logic          rep_i,
  input  logic [1:0]    rep_cond_i,
  input  logic [1:0]    size_i,
  input  logic          dir_i,
  input  logic          wide_i,
  input  logic [AW-1:0] idx_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [DW-1:0] acc_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [1:0]    mem_size_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_rdy_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] idx_o,
  output logic [CW-1:0] cnt_o,
  output logic [5:0]    flags_o
);

  logic       cfg_scan_q, cfg_rep_q, cfg_dir_q, cfg_wide_q;
  rep_cond_e  cfg_cond_q;
  elem_size_e cfg_size_q;

  logic [AW-1:0] idx_q, idx_nxt;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] acc_q;
  flags_t        flags_q, flg_nxt;

  logic accept, hs, last, stop_cond, zero_skip;

  assign zero_skip = rep_i && (cnt_i == '0);
  assign hs        = mem_req_o && mem_rdy_i;

  str_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .zero_skip_i (zero_skip),
    .hs_i        (hs),
    .last_i      (last),
    .accept_o    (accept),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  str_idx_step #(.AW(AW)) u_step (
    .idx_i     (idx_q),
    .size_i    (cfg_size_q),
    .dir_i     (cfg_dir_q),
    .wide_i    (cfg_wide_q),
    .idx_nxt_o (idx_nxt),
    .addr_o    (mem_addr_o)
  );

  str_sub_flags #(.DW(DW)) u_flags (
    .acc_i   (acc_q),
    .mem_i   (mem_rdata_i),
    .size_i  (cfg_size_q),
    .flags_o (flg_nxt)
  );

  always_comb begin
    stop_cond = cfg_scan_q &&
                (((cfg_cond_q == RC_WHILE_EQ) && !flg_nxt.zro) ||
                 ((cfg_cond_q == RC_WHILE_NE) &&  flg_nxt.zro));
    last = !cfg_rep_q || (cnt_q == CW'(1)) || stop_cond;
  end

  always_comb begin
    case (cfg_size_q)
      SZ_BYTE: mem_wdata_o = DW'(acc_q[7:0]);
      SZ_WORD: mem_wdata_o = DW'(acc_q[15:0]);
      default: mem_wdata_o = DW'(acc_q[31:0]);
    endcase
  end

  assign mem_req_o  = busy_o;
  assign mem_we_o   = !cfg_scan_q;
  assign mem_size_o = cfg_size_q;
  assign idx_o      = idx_q;
  assign cnt_o      = cnt_q;
  assign flags_o    = flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_scan_q <= 1'b0;
      cfg_rep_q  <= 1'b0;
      cfg_dir_q  <= 1'b0;
      cfg_wide_q <= 1'b1;
      cfg_cond_q <= RC_NONE;
      cfg_size_q <= SZ_BYTE;
      idx_q      <= '0;
      cnt_q      <= '0;
      acc_q      <= '0;
      flags_q    <= '0;
    end else if (accept) begin
      cfg_scan_q <= scan_i;
      cfg_rep_q  <= rep_i;
      cfg_dir_q  <= dir_i;
      cfg_wide_q <= wide_i;
      cfg_cond_q <= rep_cond_e'(rep_cond_i);
      cfg_size_q <= elem_size_e'(size_i);
      idx_q      <= idx_i;
      cnt_q      <= cnt_i;
      acc_q      <= acc_i;
    end else if (hs) begin
      idx_q <= idx_nxt;
      if (cfg_rep_q)  cnt_q   <= cnt_q - CW'(1);
      if (cfg_scan_q) flags_q <= flg_nxt;
    end
  end

endmodule

// File: rtl/str_walk_chk.sv
`timescale 1ns/1ps
module str_walk_chk
  import str_walk_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          rep_i,
  input logic [CW-1:0] cnt_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_rdy_i,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic [5:0]    flags_o,
  input logic [CW-1:0] cnt_o,
  input logic          cfg_dir_q,
  input logic          cfg_rep_q,
  input elem_size_e    cfg_size_q
);

  logic        hs;
  logic [15:0] lo_up, lo_dn;

  assign hs    = mem_req_o && mem_rdy_i;
  assign lo_up = mem_addr_o[15:0] + 16'(elem_bytes(cfg_size_q));
  assign lo_dn = mem_addr_o[15:0] - 16'(elem_bytes(cfg_size_q));

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_wdata_o) && $stable(mem_we_o));

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |=> !mem_req_o ||
           (mem_addr_o[15:0] == ($past(cfg_dir_q) ? $past(lo_dn) : $past(lo_up))));

  p_cnt_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && cfg_rep_q |=> cnt_o == $past(cnt_o) - CW'(1));

  p_cnt_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !cfg_rep_q |=> cnt_o == $past(cnt_o));

  p_zero_skip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && rep_i && (cnt_i == '0) |=> done_o && !mem_req_o);

  p_store_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && mem_we_o |=> $stable(flags_o));

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o);

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);

endmodule

bind str_walk_engine str_walk_chk #(.AW(AW), .CW(CW), .DW(DW)) u_chk (.*);

// File: tb/tb_str_walk_engine.sv
`timescale 1ns/1ps
module tb_str_walk_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 0, scan = 0, rep = 0, dir = 0, wide = 1;
  logic [1:0]  cond = 0, size = 0;
  logic [31:0] idx = 0, cnt = 0, acc = 0;
  logic        rdy = 0;
  logic [31:0] rd_val = 0, match_addr = 0, match_val = 0;
  logic        rd_sel = 0;

  logic        mem_req, mem_we, busy, done;
  logic [31:0] mem_addr, mem_wdata, rdata, idx_o, cnt_o;
  logic [1:0]  mem_size;
  logic [5:0]  flags;

  int n_chk = 0, n_fail = 0;
  int lat = 0, wcnt = 0, n_acc = 0;
  logic [31:0] last_waddr = 0, last_wdata = 0;
  logic        last_we = 0;

  always #4 clk = ~clk;

  assign rdata = (rd_sel && mem_addr == match_addr) ? match_val : rd_val;

  str_walk_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .scan_i(scan), .rep_i(rep),
    .rep_cond_i(cond), .size_i(size), .dir_i(dir), .wide_i(wide),
    .idx_i(idx), .cnt_i(cnt), .acc_i(acc),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_size_o(mem_size), .mem_rdata_i(rdata),
    .mem_rdy_i(rdy), .busy_o(busy), .done_o(done), .idx_o(idx_o),
    .cnt_o(cnt_o), .flags_o(flags)
  );

  // memory responder: ready after lat waiting cycles
  initial forever begin
    @(negedge clk);
    if (mem_req) begin
      if (wcnt >= lat) begin
        rdy = 1; wcnt = 0; n_acc++;
        last_waddr = mem_addr; last_wdata = mem_wdata; last_we = mem_we;
      end else begin
        rdy = 0; wcnt++;
      end
    end else begin
      rdy = 0; wcnt = 0;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] calc(input logic [1:0] z, input logic [31:0] a, input logic [31:0] m);
    int w;
    logic [31:0] mask, am, mm, r;
    logic cf, zf, sf, of, af, pf;
    case (z)
      2'd0: w = 8;
      2'd1: w = 16;
      default: w = 32;
    endcase
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    am = a & mask; mm = m & mask; r = (am - mm) & mask;
    cf = am < mm; zf = (r == 0); sf = r[w-1];
    of = (am[w-1] != mm[w-1]) && (r[w-1] != am[w-1]);
    af = a[3:0] < m[3:0]; pf = ~^r[7:0];
    return {of, sf, zf, af, pf, cf};
  endfunction

  task automatic run_op(input logic s, input logic r, input logic [1:0] c, input logic [1:0] z,
                        input logic d, input logic w, input logic [31:0] ix,
                        input logic [31:0] cn, input logic [31:0] ac, output int cyc);
    @(negedge clk);
    scan = s; rep = r; cond = c; size = z; dir = d; wide = w;
    idx = ix; cnt = cn; acc = ac; start = 1;
    @(negedge clk);
    start = 0; cyc = 1;
    while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
    if (!done) begin n_chk++; n_fail++; $display("FAIL R11 actual=no_done expected=done"); end
  endtask

  typedef struct packed {
    logic        scan;
    logic [1:0]  sz;
    logic        dir;
    logic        a32;
    logic [31:0] idx;
    logic [31:0] acc;
    logic [31:0] mem;
    logic [31:0] exp_idx;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 1'b0, 1'b1, 32'h0000_0100, 32'h0000_0005, 32'h0000_0007, 32'h0000_0101},
    '{1'b1, 2'd1, 1'b1, 1'b1, 32'h0000_0200, 32'h0000_8000, 32'h0000_0001, 32'h0000_01FE},
    '{1'b1, 2'd2, 1'b0, 1'b1, 32'h0000_1000, 32'h1234_5678, 32'h1234_5678, 32'h0000_1004},
    '{1'b0, 2'd2, 1'b1, 1'b1, 32'h0000_1000, 32'hCAFE_F00D, 32'h0000_0000, 32'h0000_0FFC},
    '{1'b0, 2'd0, 1'b0, 1'b0, 32'hABCD_FFFF, 32'h1122_3344, 32'h0000_0000, 32'hABCD_0000},
    '{1'b1, 2'd1, 1'b1, 1'b0, 32'h5555_0000, 32'hFFFF_0000, 32'h1234_0000, 32'h5555_FFFE},
    '{1'b1, 2'd0, 1'b1, 1'b1, 32'h0000_0010, 32'h0000_0080, 32'h0000_0001, 32'h0000_000F},
    '{1'b0, 2'd1, 1'b0, 1'b1, 32'h0000_0020, 32'h1234_BEEF, 32'h0000_0000, 32'h0000_0022}
  };

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc, acc0;
    logic [5:0] exp_f;
    logic [31:0] mask;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", done, 0);
    check("R1 req", mem_req, 0);
    check("R1 busy", busy, 0);
    check("R1 idx", idx_o, 0);
    check("R1 cnt", cnt_o, 0);
    check("R1 flags", flags, 0);
    rst_n = 1;
    exp_f = 6'd0;

    // single-element table: R2 R3 R4 R5 R10
    for (int i = 0; i < NV; i++) begin
      rd_sel = 0; rd_val = VECS[i].mem; lat = i % 3;
      acc0 = n_acc;
      run_op(VECS[i].scan, 1'b0, 2'd0, VECS[i].sz, VECS[i].dir, VECS[i].a32,
             VECS[i].idx, 32'd5, VECS[i].acc, cyc);
      check("R4/R5 idx", idx_o, VECS[i].exp_idx);
      check("R10 cnt kept", cnt_o, 5);
      check("R10 one access", n_acc - acc0, 1);
      check("R5 addr", last_waddr, VECS[i].a32 ? VECS[i].idx : (VECS[i].idx & 32'hFFFF));
      if (VECS[i].scan) begin
        exp_f = calc(VECS[i].sz, VECS[i].acc, VECS[i].mem);
        check("R3 flags", flags, exp_f);
        check("R3 we", last_we, 0);
      end else begin
        mask = (VECS[i].sz == 0) ? 32'hFF : (VECS[i].sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        check("R2 wdata", last_wdata, VECS[i].acc & mask);
        check("R2 we", last_we, 1);
        check("R2 flags kept", flags, exp_f);
      end
      @(negedge clk);
      check("R11 done pulse", done, 0);
    end

    // R6 repeat store, byte up
    lat = 0; acc0 = n_acc;
    run_op(1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 32'h40, 32'd3, 32'h77, cyc);
    check("R6 idx", idx_o, 32'h43);
    check("R6 cnt", cnt_o, 0);
    check("R6 accesses", n_acc - acc0, 3);
    check("R6 last addr", last_waddr, 32'h42);

    // R6 repeat dword down
    acc0 = n_acc;
    run_op(1'b0, 1'b1, 2'd0, 2'd2, 1'b1, 1'b1, 32'h100, 32'd2, 32'h1, cyc);
    check("R6 idx down", idx_o, 32'hF8);
    check("R6 cnt down", cnt_o, 0);
    check("R6 accesses down", n_acc - acc0, 2);

    // R7 zero count
    acc0 = n_acc;
    run_op(1'b1, 1'b1, 2'd0, 2'd1, 1'b0, 1'b1, 32'h600, 32'd0, 32'h1, cyc);
    check("R7 done timing", cyc, 1);
    check("R7 no access", n_acc - acc0, 0);
    check("R7 idx", idx_o, 32'h600);
    check("R7 cnt", cnt_o, 0);
    check("R7 flags kept", flags, exp_f);

    // R8 while-equal stops on first mismatch
    rd_sel = 1; rd_val = 32'h41; match_addr = 32'h82; match_val = 32'h42;
    run_op(1'b1, 1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 32'h80, 32'd10, 32'h41, cyc);
    check("R8 eq idx", idx_o, 32'h83);
    check("R8 eq cnt", cnt_o, 7);
    check("R8 eq flags", flags, calc(2'd0, 32'h41, 32'h42));

    // R8 while-not-equal stops on first match
    rd_val = 32'h00; match_addr = 32'h83; match_val = 32'h41;
    run_op(1'b1, 1'b1, 2'd2, 2'd0, 1'b0, 1'b1, 32'h80, 32'd10, 32'h41, cyc);
    check("R8 ne idx", idx_o, 32'h84);
    check("R8 ne cnt", cnt_o, 6);
    check("R8 ne flags", flags, calc(2'd0, 32'h41, 32'h41));
    rd_sel = 0;

    // R9 wait states: ready after 3 idle cycles
    lat = 3; acc0 = n_acc;
    run_op(1'b0, 1'b0, 2'd0, 2'd2, 1'b0, 1'b1, 32'h700, 32'd1, 32'hA5A5_5A5A, cyc);
    check("R9 latency", cyc, 5);
    check("R9 one handshake", n_acc - acc0, 1);
    check("R9 data", last_wdata, 32'hA5A5_5A5A);

    // R11 start while busy ignored
    lat = 1; acc0 = n_acc;
    @(negedge clk);
    scan = 0; rep = 1; cond = 0; size = 0; dir = 0; wide = 1;
    idx = 32'h300; cnt = 32'd4; acc = 32'h5A; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); @(negedge clk);
    check("R11 busy", busy, 1);
    idx = 32'h9000; cnt = 32'd1; start = 1;
    @(negedge clk); start = 0;
    cyc = 0;
    while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
    check("R11 idx", idx_o, 32'h304);
    check("R11 cnt", cnt_o, 0);
    check("R11 accesses", n_acc - acc0, 4);
    @(negedge clk);
    check("R11 pulse end", done, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule